// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block settles the power-up configuration of a device whose configuration pins double as clock outputs. Once the supply is reported good, every shared pin is left undriven for a fixed number of timebase cycles. During that time an external pull resistor alone sets each pin's level. On the last cycle of that window the block captures every pin level into a configuration bit. In the same cycle it turns on all the pin drivers, so the pins then carry clocks.

The captured bits are sticky. Only a loss of supply, seen as the supply-good input going low, clears them and starts the sequence again. One captured bit works as a mode strap. It chooses whether a separate dual-function pin is driven as a reference clock output or is read as a clock-stop control input.

The supply-good input comes from analog sensing. It is synchronised internally before it can start the window. Its low level clears all state asynchronously.

Top module: `strap_sampler`

## Requirements
- R1: While `supply_good` is low, `strap`, `pin_oe`, `done`, `aux_ref_oe` and `aux_stop_en` are all zero, and they become zero at once when `supply_good` falls.
- R2: With WINDOW_CYCLES = W, the first rising edge of `clk` that sees `supply_good` high is edge 1. `done` is low after edge W+1 and high after edge W+2. The two-flop synchroniser accounts for two of these edges.
- R3: While `done` is low, every bit of `pin_oe` is 0, so all shared pins stay undriven.
- R4: On the edge that raises `done`, bit i of `strap` takes the level of `pin_level[i]` at that edge: 1 for a pin pulled to supply, 0 for a pin pulled to ground. Levels present earlier in the window have no effect.
- R5: Every bit of `pin_oe` goes to 1 in the same cycle that `done` goes to 1.
- R6: Once `done` is high, changes on `pin_level` have no effect on `strap`.
- R7: `done` and `strap` hold their values for as long as `supply_good` stays high. If `supply_good` drops during the window, the whole window starts again from edge 1 of R2.
- R8: The mode strap is `strap[MODE_IDX]`, which defaults to bit 0. After `done`, a mode bit of 0 gives `aux_ref_oe`=1 and `aux_stop_en`=0, and a mode bit of 1 gives `aux_ref_oe`=0 and `aux_stop_en`=1. Before `done`, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock that counts the sampling window |
| supply_good | input | 1 | Supply-good indication; low acts as asynchronous power-off clear |
| pin_level | input | NUM_PINS | Levels read back from the shared pins |
| strap | output | NUM_PINS | Captured configuration bits |
| pin_oe | output | NUM_PINS | Per-pin output driver enables |
| done | output | 1 | Capture complete, drivers enabled |
| aux_ref_oe | output | 1 | Drive the dual-function pin as reference clock output |
| aux_stop_en | output | 1 | Read the dual-function pin as clock-stop control input |

## Verification
A window counter that is off by one moves the rise of `done` and `pin_oe` by one edge. It also makes the captured value come from the pin level one cycle early or late. The bench changes the pin levels exactly one cycle before the capture edge, so such an error shows up as a wrong `strap` value in the very cycle `done` rises. A capture register that does not hold its value shows as a changed `strap` a few cycles after the bench inverts the pins. A synchroniser or clear path that leaves state behind shows as nonzero outputs within two cycles of `supply_good` going low.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef struct packed {
    logic ref_oe;
    logic stop_en;
  } aux_role_t;

  // Index of the final counter value inside a window of w cycles.
  function automatic int unsigned window_last(input int unsigned w);
    return (w > 0) ? w - 1 : 0;
  endfunction

  // Role of the dual-function pin from the capture flag and the mode strap.
  function automatic aux_role_t aux_decode(input logic captured, input logic mode);
    aux_role_t r;
    r.ref_oe  = captured & ~mode;
    r.stop_en = captured &  mode;
    return r;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync (
  input  logic clk,
  input  logic arst_n,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= 1'b1;
      q    <= meta;
    end
  end
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  output logic fire
);
  import strap_pkg::*;

  localparam int unsigned CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(window_last(WINDOW_CYCLES));

  logic [CW-1:0] cnt;

  assign fire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt <= '0;
    end else if (run && !fire) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned NUM_PINS = 5
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                fire,
  input  logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] strap,
  output logic                done
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      done <= 1'b0;
    end else if (fire) begin
      done <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        strap[i] <= 1'b0;
      end else if (fire && !done) begin
        strap[i] <= pin_level[i];
      end
    end
  end
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int unsigned NUM_PINS      = 5,
  parameter int unsigned WINDOW_CYCLES = 28636,
  parameter int unsigned MODE_IDX      = 0
) (
  input  logic                clk,
  input  logic                supply_good,
  input  logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] strap,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                done,
  output logic                aux_ref_oe,
  output logic                aux_stop_en
);
  import strap_pkg::*;

  logic      rdy;
  logic      fire;
  logic      run;
  aux_role_t role;

  strap_sync u_sync (
    .clk   (clk),
    .arst_n(supply_good),
    .q     (rdy)
  );

  assign run = rdy & ~done;

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk   (clk),
    .arst_n(supply_good),
    .run   (run),
    .fire  (fire)
  );

  strap_capture #(.NUM_PINS(NUM_PINS)) u_cap (
    .clk      (clk),
    .arst_n   (supply_good),
    .fire     (fire),
    .pin_level(pin_level),
    .strap    (strap),
    .done     (done)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_oe
    assign pin_oe[i] = done;
  end

  assign role        = aux_decode(done, strap[MODE_IDX]);
  assign aux_ref_oe  = role.ref_oe;
  assign aux_stop_en = role.stop_en;
endmodule

// File: rtl/strap_checker.sv
module strap_checker #(
  parameter int unsigned NUM_PINS = 5
) (
  input logic                clk,
  input logic                supply_good,
  input logic [NUM_PINS-1:0] pin_level,
  input logic [NUM_PINS-1:0] strap,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                done,
  input logic                aux_ref_oe,
  input logic                aux_stop_en,
  input logic                rdy,
  input logic                fire
);
  // R4: capture takes the pin levels of the firing edge
  a_r4_capture_on_fire: assert property (@(posedge clk) disable iff (!supply_good)
    fire |=> (done && strap == $past(pin_level)));

  // R2: done only rises after the synchroniser reported supply good
  a_r2_done_after_sync: assert property (@(posedge clk) disable iff (!supply_good)
    $rose(done) |-> $past(rdy));

  // R7: done is sticky while supply stays good
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!supply_good)
    done |=> done);

  // R6: captured bits do not move after done
  a_r6_strap_frozen: assert property (@(posedge clk) disable iff (!supply_good)
    done |=> $stable(strap));

  // R7: the window fires only once per power cycle
  a_r7_single_fire: assert property (@(posedge clk) disable iff (!supply_good)
    fire |-> !done);

  // R3: drivers stay off until done
  a_r3_hiz_before_done: assert property (@(posedge clk) disable iff (!supply_good)
    !done |-> (pin_oe == '0));

  // R8: auxiliary pin roles are exclusive and wait for done
  a_r8_aux_exclusive: assert property (@(posedge clk) disable iff (!supply_good)
    $onehot0({aux_ref_oe, aux_stop_en}) && (done || !(aux_ref_oe || aux_stop_en)));
endmodule

bind strap_sampler strap_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .supply_good(supply_good),
  .pin_level  (pin_level),
  .strap      (strap),
  .pin_oe     (pin_oe),
  .done       (done),
  .aux_ref_oe (aux_ref_oe),
  .aux_stop_en(aux_stop_en),
  .rdy        (rdy),
  .fire       (fire)
);

// File: tb/sim_strap_sampler.sv
module sim_strap_sampler;
  localparam int N = 5;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         supply_good = 1'b0;
  logic [N-1:0] pin_level = '0;
  logic [N-1:0] strap, pin_oe;
  logic         done, aux_ref_oe, aux_stop_en;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  strap_sampler #(.NUM_PINS(N), .WINDOW_CYCLES(W), .MODE_IDX(0)) u0 (
    .clk(clk), .supply_good(supply_good), .pin_level(pin_level),
    .strap(strap), .pin_oe(pin_oe), .done(done),
    .aux_ref_oe(aux_ref_oe), .aux_stop_en(aux_stop_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int p = 0; p < (1 << N); p++) begin
      @(negedge clk);
      supply_good = 1'b0;
      pin_level   = ~N'(p);
      repeat (2) @(negedge clk);
      chk("R1 strap clear",  32'(strap), 0);
      chk("R1 oe clear",     32'(pin_oe), 0);
      chk("R1 done clear",   32'(done), 0);
      chk("R1 aux clear",    32'({aux_ref_oe, aux_stop_en}), 0);
      supply_good = 1'b1;
      if (p == 7 || p == 22) begin
        repeat (W / 2) @(negedge clk);
        chk("R3 undriven mid-window", 32'(pin_oe), 0);
        supply_good = 1'b0;
        @(negedge clk);
        chk("R7 drop clears done", 32'(done), 0);
        supply_good = 1'b1;
      end
      repeat (W + 1) @(negedge clk);
      chk("R2 done low at edge W+1", 32'(done), 0);
      chk("R3 undriven before done", 32'(pin_oe), 0);
      chk("R8 aux idle before done", 32'({aux_ref_oe, aux_stop_en}), 0);
      pin_level = N'(p);
      @(negedge clk);
      chk("R2 done high at edge W+2", 32'(done), 1);
      chk("R5 drivers on with done",  32'(pin_oe), 32'((1 << N) - 1));
      chk("R4 captured levels",       32'(strap), 32'(p));
      chk("R8 aux role",              32'({aux_ref_oe, aux_stop_en}),
                                      (p % 2 == 1) ? 32'h1 : 32'h2);
      pin_level = ~N'(p);
      repeat (4) @(negedge clk);
      chk("R6 strap ignores pins", 32'(strap), 32'(p));
      chk("R7 done held",          32'(done), 1);
    end
    finish_run();
  end
endmodule